// File: doc/BRIEF.md
# Pin Event Timestamp Unit

The unit stamps transitions on one asynchronous input pin with the value of a free-running time base. The pin passes through a synchronizer. An edge qualifier then decides which transitions count, according to a 3-bit mode. The modes cover falling only, rising only, both polarities, both polarities after a chosen first polarity, and every 4th or every 16th rising edge. For each qualifying transition, the current time base is written into a small first-in first-out store.

The time base comes from two external 16-bit counters. Either counter can be used alone, zero-extended to 32 bits. The two can also be joined into one 32-bit count. Software drains the store through a valid/ready read port and watches three status signals: the not-empty indication (`rd_valid`), a sticky overflow flag, and a threshold interrupt pulse.

Read-port rules: `rd_valid` is high whenever the store holds an entry. `rd_data` shows the oldest entry while `rd_valid` is high. An entry is removed on a rising clock edge where `rd_valid` and `rd_ready` are both high. The unit never stalls capture because of the read side. When the store is full, new captures are dropped and flagged instead.

Top module: `icap_unit`

## Requirements
- R1: A pin transition that qualifies is written to the store on the third rising clock edge after the pin changes. The stored value is the time base sampled at that edge.
- R2: Mode encoding: 2 = falling edges only, 3 = rising edges only, 6 = every edge of either polarity. Mode 0 and mode 7 capture nothing.
- R3: Mode 1 captures every edge of either polarity, but only after a first edge whose polarity is given by `first_rise` (1 = rising, 0 = falling). Edges of the other polarity are ignored until that first capture.
- R4: Mode 4 captures on every 4th rising edge and mode 5 on every 16th rising edge, counted from mode entry. The first capture comes on the 4th or 16th rising edge respectively.
- R5: With `wide` = 0 the value is `tmr_b` when `sel_b` = 1, else `tmr_a`, zero-extended to 32 bits. With `wide` = 1 the value is {`tmr_b`, `tmr_a`}, with `tmr_b` in bits 31:16.
- R6: The store holds 4 entries and returns them oldest first. `rd_valid` is high exactly when at least one entry is held.
- R7: A capture that arrives while 4 entries are held is discarded and sets `ovf`. The held entries are kept. `ovf` stays set until a cycle with `ovf_clr` high.
- R8: `irq` is a one-cycle pulse. It fires after `irq_thr`+1 entries have been stored since the previous pulse or clear; dropped captures do not count.
- R9: `rd_ready` with an empty store changes nothing. `rd_data` keeps the last value removed.
- R10: `en` low, or any change of `mode`, empties the store. It also clears `ovf`, the prescale count, the interrupt entry count and the first-edge state. While `en` is low, nothing is captured.
- R11: After reset, `rd_valid`, `ovf` and `irq` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enable; low clears and blocks capture |
| mode | input | 3 | Capture mode select |
| first_rise | input | 1 | First-edge polarity for mode 1 |
| sel_b | input | 1 | Single-counter select (0 = tmr_a, 1 = tmr_b) |
| wide | input | 1 | Use the 32-bit joined time base |
| irq_thr | input | 2 | Interrupt after irq_thr+1 stored entries |
| tmr_a | input | 16 | Time base counter A |
| tmr_b | input | 16 | Time base counter B |
| cap_pin | input | 1 | Asynchronous event pin |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_ready | input | 1 | Read side accepts the head entry |
| rd_valid | output | 1 | Store not empty; head entry on rd_data |
| rd_data | output | 32 | Head entry, or last removed value when empty |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Threshold interrupt pulse |

## Verification
The assertions take for granted that every input except `cap_pin` is synchronous to `clk`. They also assume the synchronizer runs from reset, so the history of the sampled pin is valid. The stimulus changes every input, the pin included, only on falling clock edges. It spaces pin transitions by four cycles, so each transition has left the edge detector before the next arrives or the configuration changes. Mode and enable changes are made only after earlier edges have settled. This keeps each clear from colliding with a pending capture.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    CM_OFF    = 3'd0,
    CM_FIRST  = 3'd1,
    CM_FALL   = 3'd2,
    CM_RISE   = 3'd3,
    CM_RISE4  = 3'd4,
    CM_RISE16 = 3'd5,
    CM_BOTH   = 3'd6,
    CM_NONE   = 3'd7
  } cap_mode_e;
endpackage

// File: rtl/icap_event.sv
module icap_event #(
  parameter int SYNC = 2,
  parameter int PS_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  icap_pkg::cap_mode_e  mode,
  input  logic                 first_rise,
  input  logic                 pin,
  output logic                 ev
);
  import icap_pkg::*;

  localparam logic [PS_W-1:0] LAST4  = PS_W'(3);
  localparam logic [PS_W-1:0] LAST16 = PS_W'(15);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise, fall;
  logic [PS_W-1:0] pcnt;
  logic            armed;
  logic            hit;
  logic            prescaled;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC-1];

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign fall = ~sync_q[SYNC-1] & prev_q;
  assign prescaled = (mode == CM_RISE4) || (mode == CM_RISE16);

  always_comb begin
    unique case (mode)
      CM_FALL:   hit = fall;
      CM_RISE:   hit = rise;
      CM_BOTH:   hit = rise | fall;
      CM_FIRST:  hit = armed ? (rise | fall) : (first_rise ? rise : fall);
      CM_RISE4:  hit = rise && (pcnt == LAST4);
      CM_RISE16: hit = rise && (pcnt == LAST16);
      default:   hit = 1'b0;
    endcase
  end

  assign ev = hit & en & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      pcnt  <= '0;
      armed <= 1'b0;
    end else begin
      if (en && prescaled && rise)
        pcnt <= hit ? '0 : pcnt + 1'b1;
      if (mode == CM_FIRST && ev)
        armed <= 1'b1;
    end
  end

  p_arm_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(ev));
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ovf_clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ovf,
  output logic          stored
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [DW-1:0] last_q;
  logic          full, empty, push, pop;

  assign full   = (count == FULL_C);
  assign empty  = (count == '0);
  assign push   = wr & ~full & ~clr;
  assign pop    = rd_ready & ~empty & ~clr;
  assign stored = push;

  assign rd_valid = ~empty;
  assign rd_data  = empty ? last_q : mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0; last_q <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (pop) begin
        rp     <= (rp == LAST_P) ? '0 : rp + 1'b1;
        last_q <= mem[rp];
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr && full)   ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  p_full_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_ready && !clr) |=> full);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr && !clr) |=> ovf);
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr && !clr) |=> (!rd_valid && $stable(rd_data)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rd_valid && !ovf));
endmodule

// File: rtl/icap_irq.sv
module icap_irq #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          store,
  input  logic [TW-1:0] thr,
  output logic          irq
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; irq <= 1'b0;
    end else if (clr) begin
      cnt <= '0; irq <= 1'b0;
    end else if (store) begin
      if (cnt == thr) begin
        cnt <= '0; irq <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1; irq <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end

  p_irq_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(store));
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int TMR_W = 16,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2,
  parameter int THR_W = 2,
  localparam int DW   = 2 * TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       mode,
  input  logic             first_rise,
  input  logic             sel_b,
  input  logic             wide,
  input  logic [THR_W-1:0] irq_thr,
  input  logic [TMR_W-1:0] tmr_a,
  input  logic [TMR_W-1:0] tmr_b,
  input  logic             cap_pin,
  input  logic             ovf_clr,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             ovf,
  output logic             irq
);
  import icap_pkg::*;

  cap_mode_e   mode_e, mode_q;
  logic        clr, ev, stored;
  logic [DW-1:0] stamp;

  assign mode_e = cap_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= CM_OFF;
    else        mode_q <= mode_e;

  assign clr   = ~en | (mode_e != mode_q);
  assign stamp = wide  ? {tmr_b, tmr_a}
               : sel_b ? {{TMR_W{1'b0}}, tmr_b}
               :         {{TMR_W{1'b0}}, tmr_a};

  icap_event #(.SYNC(SYNC), .PS_W(4)) u_event (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .mode(mode_e),
    .first_rise(first_rise), .pin(cap_pin), .ev(ev)
  );

  icap_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ovf_clr(ovf_clr), .wr(ev),
    .wdata(stamp), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .ovf(ovf), .stored(stored)
  );

  icap_irq #(.TW(THR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .store(stored), .thr(irq_thr),
    .irq(irq)
  );

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);
endmodule

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, first_rise = 1'b0, sel_b = 1'b0, wide = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] irq_thr = 2'd0;
  logic cap_pin = 1'b0, ovf_clr = 1'b0, rd_ready = 1'b0;
  logic [15:0] tmr_a, tmr_b;
  logic rd_valid, ovf, irq;
  logic [31:0] rd_data;

  logic [31:0] cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;
  assign tmr_a = cyc[15:0];
  assign tmr_b = cyc[15:0] ^ 16'hA5A5;

  icap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .first_rise(first_rise),
    .sel_b(sel_b), .wide(wide), .irq_thr(irq_thr), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .cap_pin(cap_pin), .ovf_clr(ovf_clr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf), .irq(irq)
  );

  int checks = 0, fails = 0, irq_seen = 0;
  logic [31:0] q[$];
  logic [31:0] last_pop = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design hands them out
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (irq) irq_seen++;
      if (rd_valid && rd_ready) begin
        if (q.size() == 0) chk(0, "R6 unexpected entry", rd_data, 32'h0);
        else begin
          logic [31:0] e;
          e = q.pop_front();
          chk(rd_data == e, "R6 order/value", rd_data, e);
        end
        last_pop = rd_data;
      end
    end
  end

  function automatic logic [31:0] stamp_now();
    return wide ? {tmr_b, tmr_a} : (sel_b ? {16'h0, tmr_b} : {16'h0, tmr_a});
  endfunction

  // driver: changes the pin and predicts the stored entry (R1, R5)
  task automatic toggle(input logic v, input bit qual);
    @(negedge clk);
    cap_pin = v;
    repeat (3) @(posedge clk);
    if (qual) begin
      if (q.size() < 4) q.push_back(stamp_now());
    end
    @(negedge clk);
  endtask

  task automatic cfg(input logic e, input logic [2:0] m, input logic fr,
                     input logic sb, input logic w, input logic [1:0] t);
    bit clears;
    clears = (m != mode) || !e;
    @(negedge clk);
    en = e; mode = m; first_rise = fr; sel_b = sb; wide = w; irq_thr = t;
    @(negedge clk);
    if (clears) q.delete();
  endtask

  task automatic settle();
    @(negedge clk); #3;
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    rd_ready = 1'b1;
    for (int i = 0; i < 40 && q.size() > 0; i++) @(negedge clk);
    @(negedge clk);
    rd_ready = 1'b0;
    #3;
    chk(q.size() == 0, {tag, " all expected entries seen"}, q.size(), 0);
    chk(!rd_valid, {tag, " store empty after drain"}, rd_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int r;
    repeat (3) @(negedge clk);
    #3;
    // R11 reset state
    chk(!rd_valid, "R11 rd_valid", rd_valid, 0);
    chk(!ovf, "R11 ovf", ovf, 0);
    chk(!irq, "R11 irq", irq, 0);
    chk(rd_data == 0, "R11 rd_data", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 latency, rising mode, counter A
    cfg(1, 3'd3, 0, 0, 0, 2'd3);
    @(negedge clk); cap_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #3;
    chk(!rd_valid, "R1 not written after two edges", rd_valid, 0);
    @(posedge clk);
    q.push_back(stamp_now());
    @(negedge clk); #3;
    chk(rd_valid, "R1 written on third edge", rd_valid, 1);
    chk(rd_data == q[0], "R1 stamp at third edge", rd_data, q[0]);
    toggle(0, 0);
    drain("R1");

    // R2 falling only, R5 counter B
    cfg(1, 3'd2, 0, 1, 0, 2'd3);
    toggle(1, 0); toggle(0, 1); toggle(1, 0); toggle(0, 1);
    drain("R2 fall R5 sel_b");

    // R2 both edges, R5 wide
    cfg(1, 3'd6, 0, 0, 1, 2'd3);
    toggle(1, 1); toggle(0, 1); toggle(1, 1);
    drain("R2 both R5 wide");
    toggle(0, 1);
    drain("R2 both last");

    // R2 mode 7 captures nothing
    cfg(1, 3'd7, 0, 0, 0, 2'd3);
    toggle(1, 0); toggle(0, 0);
    settle();
    chk(!rd_valid, "R2 mode 7 no capture", rd_valid, 0);

    // R3 first edge falling
    cfg(1, 3'd1, 0, 0, 0, 2'd3);
    toggle(1, 0); toggle(0, 1); toggle(1, 1); toggle(0, 1);
    drain("R3 first fall");

    // R3 first edge rising, pin raised while disabled (R10 no capture)
    cfg(0, 3'd1, 1, 0, 0, 2'd3);
    toggle(1, 0);
    settle();
    chk(!rd_valid, "R10 disabled no capture", rd_valid, 0);
    cfg(1, 3'd1, 1, 0, 0, 2'd3);
    toggle(0, 0); toggle(1, 1); toggle(0, 1);
    drain("R3 first rise");

    // R4 divide by 4
    cfg(1, 3'd4, 0, 0, 0, 2'd3);
    r = 0;
    for (int i = 0; i < 8; i++) begin
      toggle(1, (r % 4) == 3); r++;
      toggle(0, 0);
    end
    chk(q.size() == 2, "R4 div4 two entries", q.size(), 2);
    drain("R4 div4");

    // R4 divide by 16
    cfg(1, 3'd5, 0, 0, 0, 2'd3);
    r = 0;
    for (int i = 0; i < 17; i++) begin
      toggle(1, (r % 16) == 15); r++;
      toggle(0, 0);
    end
    chk(q.size() == 1, "R4 div16 one entry", q.size(), 1);
    drain("R4 div16");

    // R8 threshold 3 entries
    cfg(1, 3'd3, 0, 0, 0, 2'd2);
    base = irq_seen;
    toggle(1, 1); toggle(0, 0); toggle(1, 1); toggle(0, 0);
    settle();
    chk(irq_seen == base, "R8 no irq after two", irq_seen - base, 0);
    toggle(1, 1);
    settle();
    chk(irq_seen == base + 1, "R8 one-cycle irq after three", irq_seen - base, 1);
    toggle(0, 0);
    drain("R8");

    // R7 overflow with threshold 4
    cfg(1, 3'd3, 0, 0, 0, 2'd3);
    base = irq_seen;
    for (int i = 0; i < 5; i++) begin
      toggle(1, 1); toggle(0, 0);
      settle();
      if (i == 3) begin
        chk(irq_seen == base + 1, "R8 irq after four", irq_seen - base, 1);
        chk(!ovf, "R7 no ovf at four", ovf, 0);
      end
    end
    chk(ovf, "R7 ovf set", ovf, 1);
    chk(irq_seen == base + 1, "R8 dropped entry not counted", irq_seen - base, 1);
    drain("R7 kept entries");
    chk(ovf, "R7 ovf sticky", ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    #3;
    chk(!ovf, "R7 ovf cleared", ovf, 0);

    // R9 empty read
    @(negedge clk); rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    chk(!rd_valid, "R9 still empty", rd_valid, 0);
    chk(rd_data == last_pop, "R9 last value held", rd_data, last_pop);
    @(negedge clk); rd_ready = 1'b0;
    toggle(1, 1); toggle(0, 0);
    drain("R9 after empty read");

    // R10 mode change empties
    toggle(1, 1); toggle(0, 0); toggle(1, 1); toggle(0, 0);
    settle();
    chk(rd_valid, "R10 entries present", rd_valid, 1);
    cfg(1, 3'd6, 0, 0, 0, 2'd3);
    #3;
    chk(!rd_valid, "R10 mode change empties", rd_valid, 0);

    // R10 disable clears ovf
    cfg(1, 3'd3, 0, 0, 0, 2'd3);
    for (int i = 0; i < 5; i++) begin toggle(1, 1); toggle(0, 0); end
    settle();
    chk(ovf, "R10 ovf before disable", ovf, 1);
    cfg(0, 3'd3, 0, 0, 0, 2'd3);
    #3;
    chk(!ovf, "R10 disable clears ovf", ovf, 0);
    chk(!rd_valid, "R10 disable empties", rd_valid, 0);

    // R10 interrupt count cleared by mode change
    cfg(1, 3'd3, 0, 0, 0, 2'd1);
    base = irq_seen;
    toggle(1, 1); toggle(0, 0);
    cfg(1, 3'd2, 0, 0, 0, 2'd1);
    cfg(1, 3'd3, 0, 0, 0, 2'd1);
    toggle(1, 1); toggle(0, 0);
    settle();
    chk(irq_seen == base, "R10 irq count restarted", irq_seen - base, 0);
    toggle(1, 1);
    settle();
    chk(irq_seen == base + 1, "R10 irq after two new entries", irq_seen - base, 1);
    drain("R10 tail");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule